// File: doc/BRIEF.md
# Legacy memory attribute router

This block steers each access that falls into the legacy area between 640 KB and 1 MB. Thirteen segments in that area carry their own pair of enable bits, one for reads and one for writes. The response is either main memory or a forward to the PCI side. Processor accesses and bus-master accesses use the same attributes, so the request port has no initiator field. Addresses that the block does not decode get a third answer, "not decoded".

Seven byte-wide attribute registers sit at configuration offsets 59h to 5Fh and are accessed through a simple configuration port. Each register holds two 4-bit fields. A request presents an address, a direction bit and a valid strobe. One clock later the block returns a registered decision.

Because the read and write enables are separate, a segment can be read/write, read-only, write-only or disabled. A typical use is to copy ROM into shadow RAM with the segment set write-only, then switch it to read-only.

Top module: `lam_router`

## Requirements
- R1: After synchronous reset every attribute register reads 00h and `rsp_valid` is 0. A read request at C0000h then returns forward (route code 2).
- R2: Configuration offsets 59h through 5Fh are writable and read back through `cfg_rdata`. Any other offset reads 00h and ignores writes, so a write there leaves the registers at 59h and 5Fh unchanged.
- R3: In every register, bits 2, 3, 6 and 7 (the upper two bits of each nibble) read 0 whatever value was written. The low nibble of the register at 59h always reads 0.
- R4: A read request (`req_write`=0) to a decoded segment returns main memory (route code 1) when that segment's read-enable bit (bit 0 of its nibble) is 1. When the bit is 0 it returns forward (route code 2).
- R5: A write request (`req_write`=1) to a decoded segment returns main memory when that segment's write-enable bit (bit 1 of its nibble) is 1, and forward when it is 0. This does not depend on the read-enable bit.
- R6: The high nibble of the register at 59h controls the 64 KB segment F0000h–FFFFFh.
- R7: The register at 5Ah+j (j = 0..5) controls the 32 KB span starting at C0000h + j·8000h. Its low nibble covers the lower 16 KB of that span and its high nibble the upper 16 KB.
- R8: A request below C0000h, which includes A0000h–BFFFFh and everything below A0000h, returns not decoded (route code 0) with `rsp_valid` = 1.
- R9: `rsp_valid` equals the previous cycle's `req_valid`. When `rsp_valid` is 0, `rsp_route` is 0.
- R10: A configuration write changes decisions only for requests sampled on later clocks. A request sampled on the same edge as the write sees the old attributes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset for write and readback |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the register at `cfg_addr` (combinational) |
| req_valid | input | 1 | Request valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 20 | Byte address of the access |
| rsp_valid | output | 1 | Decision valid, one clock after the request |
| rsp_route | output | 2 | 0 = not decoded, 1 = main memory, 2 = forward to PCI |

## Verification
If one attribute bit were stored wrongly, only one segment in one direction would be misrouted. That shows up on the very next request to that segment, one clock after it is sampled. The bench therefore programs a distinct pattern into every register and probes both directions near the edges of each 16 KB segment. A wrong segment index would send a request to a neighbour's attributes, and the chosen pattern gives adjacent segments different answers so that such an error appears. A stale or premature register update shows up only in the same-edge write-and-request case, which the bench covers with a directed test.

// File: rtl/lam_pkg.sv
package lam_pkg;

    localparam int ADDR_W    = 20;
    localparam int CFG_W     = 8;
    localparam int NUM_REGS  = 7;
    localparam int NUM_FLDS  = 2 * NUM_REGS;
    localparam int FIDX_W    = $clog2(NUM_FLDS);
    localparam logic [CFG_W-1:0] REG_BASE = 8'h59;

    localparam int SEG_SHIFT   = 14;
    localparam int SMALL_SEGS  = 12;
    localparam logic [ADDR_W-1:0] DEC_BASE  = 20'hC0000;
    localparam logic [ADDR_W-1:0] SMALL_TOP = DEC_BASE + ADDR_W'(SMALL_SEGS << SEG_SHIFT);
    localparam logic [FIDX_W-1:0] TOP_FIELD   = FIDX_W'(1);
    localparam logic [FIDX_W-1:0] SMALL_FIELD = FIDX_W'(2);

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_MEM  = 2'd1,
        ROUTE_FWD  = 2'd2
    } route_e;

    typedef struct packed {
        logic              hit;
        logic [FIDX_W-1:0] fidx;
    } seg_sel_t;

    function automatic logic [CFG_W-1:0] pack_reg(input logic we_hi, input logic re_hi,
                                                  input logic we_lo, input logic re_lo);
        return {2'b00, we_hi, re_hi, 2'b00, we_lo, re_lo};
    endfunction

endpackage

// File: rtl/lam_attr_regs.sv
module lam_attr_regs
    import lam_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [CFG_W-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    output logic [NUM_FLDS-1:0]  re_vec,
    output logic [NUM_FLDS-1:0]  we_vec
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic [CFG_W-1:0] MY_OFF = REG_BASE + CFG_W'(r);
        logic sel_w;
        assign sel_w = cfg_wr && (cfg_addr == MY_OFF);

        for (genvar h = 0; h < 2; h++) begin : g_nib
            localparam int F = 2 * r + h;
            if (F == 0) begin : g_unused
                assign re_vec[F] = 1'b0;
                assign we_vec[F] = 1'b0;
            end else begin : g_fld
                logic re_q, we_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        re_q <= 1'b0;
                        we_q <= 1'b0;
                    end else if (sel_w) begin
                        re_q <= cfg_wdata[4*h];
                        we_q <= cfg_wdata[4*h+1];
                    end
                end
                assign re_vec[F] = re_q;
                assign we_vec[F] = we_q;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (cfg_addr == REG_BASE + CFG_W'(r))
                cfg_rdata = pack_reg(we_vec[2*r+1], re_vec[2*r+1], we_vec[2*r], re_vec[2*r]);
        end
    end

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & 8'hCC) == 8'h00);

    p_unused_low_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == REG_BASE) |-> (cfg_rdata[3:0] == 4'h0));

    p_bad_offset_r2: assert property (@(posedge clk) disable iff (rst)
        ((cfg_addr < REG_BASE) || (cfg_addr >= REG_BASE + CFG_W'(NUM_REGS)))
        |-> (cfg_rdata == 8'h00));

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (re_vec == '0 && we_vec == '0));

endmodule

// File: rtl/lam_seg_decode.sv
module lam_seg_decode
    import lam_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output seg_sel_t          sel
);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr - DEC_BASE;
        sel.hit  = (addr >= DEC_BASE);
        if (addr >= SMALL_TOP)
            sel.fidx = TOP_FIELD;
        else
            sel.fidx = SMALL_FIELD + FIDX_W'(off >> SEG_SHIFT);
        if (!sel.hit)
            sel.fidx = '0;
    end

endmodule

// File: rtl/lam_route_core.sv
module lam_route_core
    import lam_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  seg_sel_t            sel,
    input  logic [NUM_FLDS-1:0] re_vec,
    input  logic [NUM_FLDS-1:0] we_vec,
    output logic                rsp_valid,
    output route_e              rsp_route
);

    route_e next_route;
    logic   en_bit;

    always_comb begin
        en_bit = req_write ? we_vec[sel.fidx] : re_vec[sel.fidx];
        if (!sel.hit)
            next_route = ROUTE_NONE;
        else if (en_bit)
            next_route = ROUTE_MEM;
        else
            next_route = ROUTE_FWD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_route <= ROUTE_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_route <= req_valid ? next_route : ROUTE_NONE;
        end
    end

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid));

    p_idle_none_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_route == ROUTE_NONE));

    p_claim_needs_hit_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sel.hit) |=> (rsp_route == ROUTE_NONE));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid);

endmodule

// File: rtl/lam_router.sv
module lam_router
    import lam_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [19:0] req_addr,
    output logic        rsp_valid,
    output logic [1:0]  rsp_route
);

    logic [NUM_FLDS-1:0] re_vec;
    logic [NUM_FLDS-1:0] we_vec;
    seg_sel_t            sel;
    route_e              route_q;

    lam_attr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .re_vec    (re_vec),
        .we_vec    (we_vec)
    );

    lam_seg_decode u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    lam_route_core u_core (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .sel       (sel),
        .re_vec    (re_vec),
        .we_vec    (we_vec),
        .rsp_valid (rsp_valid),
        .rsp_route (route_q)
    );

    assign rsp_route = route_q;

    p_low_addr_none_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr < 20'hC0000) |=> (rsp_valid && rsp_route == 2'd0));

    p_route_code_legal_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_route != 2'd3);

endmodule

// File: tb/lam_router_tb.sv
module lam_router_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        req_valid;
    logic        req_write;
    logic [19:0] req_addr;
    logic        rsp_valid;
    logic [1:0]  rsp_route;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    lam_router u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route)
    );

    // entry: [22] write, [21:2] address, [1:0] expected route (0 none, 1 mem, 2 fwd)
    localparam int NV = 22;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 20'hFFFF0, 2'd1},  // R6 top segment read-only
        {1'b1, 20'hF8000, 2'd2},  // R6
        {1'b0, 20'hC0000, 2'd1},  // R7 5A low RE
        {1'b1, 20'hC0000, 2'd2},  // R5
        {1'b0, 20'hC4000, 2'd2},  // R7 5A high WE only
        {1'b1, 20'hC7FFF, 2'd1},  // R5
        {1'b0, 20'hCA000, 2'd1},  // R4 rw
        {1'b1, 20'hCE000, 2'd1},
        {1'b0, 20'hD0000, 2'd2},  // disabled
        {1'b1, 20'hD6000, 2'd2},
        {1'b0, 20'hD8000, 2'd2},  // write-only
        {1'b1, 20'hD8000, 2'd1},
        {1'b0, 20'hDC000, 2'd1},  // read-only
        {1'b1, 20'hDFFFF, 2'd2},
        {1'b0, 20'hE4000, 2'd2},  // R3 reserved bits ignored
        {1'b0, 20'hE8000, 2'd1},
        {1'b1, 20'hE8000, 2'd2},
        {1'b1, 20'hEFFFF, 2'd1},
        {1'b0, 20'hA0000, 2'd0},  // R8
        {1'b1, 20'hBFFFF, 2'd0},
        {1'b0, 20'h9FFFF, 2'd0},
        {1'b0, 20'h00000, 2'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic do_req(input string req, input logic w, input logic [19:0] a,
                          input logic [1:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {31'h0, rsp_valid}, 32'h1);
        check(req, {30'h0, rsp_route}, {30'h0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = 8'h00; cfg_wdata = 8'h00;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        for (int i = 0; i < 7; i++) cfg_check("R1 reg", 8'h59 + 8'(i), 8'h00);
        do_req("R1 reset read", 1'b0, 20'hC0000, 2'd2);

        // R2 out-of-range offsets ignored
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_check("R2 58", 8'h58, 8'h00);
        cfg_check("R2 60", 8'h60, 8'h00);
        cfg_check("R2 59", 8'h59, 8'h00);
        cfg_check("R2 5F", 8'h5F, 8'h00);

        // program pattern
        cfg_write(8'h59, 8'h1F);
        cfg_write(8'h5A, 8'h21);
        cfg_write(8'h5B, 8'h3F);
        cfg_write(8'h5C, 8'h00);
        cfg_write(8'h5D, 8'h12);
        cfg_write(8'h5E, 8'hC0);
        cfg_write(8'h5F, 8'h31);

        // R3 readback masks
        cfg_check("R3 59", 8'h59, 8'h10);
        cfg_check("R2 5A", 8'h5A, 8'h21);
        cfg_check("R3 5B", 8'h5B, 8'h33);
        cfg_check("R3 5E", 8'h5E, 8'h00);
        cfg_check("R2 5F", 8'h5F, 8'h31);

        // table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++)
            do_req("R4/R5 table", VEC[i][22], VEC[i][21:2], VEC[i][1:0]);

        // R9 idle
        @(negedge clk);
        check("R9 idle valid", {31'h0, rsp_valid}, 32'h0);
        check("R9 idle route", {30'h0, rsp_route}, 32'h0);

        // R10 same-edge write and request sees old attribute
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h00;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'hC0000;
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        check("R10 old attr", {30'h0, rsp_route}, 32'h1);
        do_req("R10 new attr", 1'b0, 20'hC0000, 2'd2);

        // R1 reset clears programmed state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        cfg_check("R1 after reset", 8'h5F, 8'h00);
        do_req("R1 after reset route", 1'b0, 20'hFFFF0, 2'd2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule